// File: doc/BRIEF.md
# Virtual Interrupt Routing Controller

This block decides where each of three asynchronous interrupt types (FIQ, IRQ and the system error or asynchronous abort) is delivered. It also produces the virtual interrupt requests that a hypervisor presents to a guest. It reads the interrupt fields of a hypervisor configuration register as plain inputs:

- three routing bits;
- three virtual pending bits;
- a trap-general-exceptions bit.

It combines them with the security state, per-type EL3 routing overrides and the current exception level.

For each type it reports a target exception level and a registered copy of the physical line. It also reports a virtual request line. When the general-exception trap is set in non-secure state, the routing bits behave as set, but their stored values are not changed. In the same condition every virtual request is held off.

The outputs are registered once. A change on any input therefore shows on the outputs one clock later. Masking by processor state flags and exception priority are handled elsewhere.

Top module: `vic_top`

## Requirements
- R1: While reset is asserted, and on the first edge after it, all outputs are 0. Each target field reads 0, meaning no target.
- R2: Type index 0 is FIQ, 1 is IRQ and 2 is system error. The target field for type t is `tgt_el[2t+1:2t]`, encoded 1 = EL1, 2 = EL2, 3 = EL3. If the EL3 override bit for a type is 1, that type targets EL3 regardless of every other input.
- R3: Without its override, a type targets EL3 whenever the current level (`cur_el`, 0 to 3) is 3.
- R4: Without its override, below EL3 and with `sec_ns` = 1, a type whose routing bit is 1 targets EL2.
- R5: Without its override, below EL3, with its routing bit effectively 0, a type targets EL1 from EL0 or EL1 and EL2 from EL2.
- R6: With `sec_ns` = 1 and `cfg_tge` = 1, every type without an override targets EL2 when the current level is below EL3, even when its routing bit is 0.
- R7: With `sec_ns` = 0, routing bits and `cfg_tge` are ignored: from EL0 or EL1 the target is EL1.
- R8: `vreq[t]` is 1 exactly when all of the following hold: `cfg_pend[t]` = 1, `cfg_route[t]` = 1, `sec_ns` = 1, `cfg_tge` = 0, and `cur_el` is 0 or 1.
- R9: With `cfg_tge` = 1 and `sec_ns` = 1, every `vreq` bit is 0, whatever the pending and routing bits are.
- R10: Every output reflects the inputs of the previous clock edge. An input change leaves the outputs unchanged until the next rising edge.
- R11: `evt_out[t]` equals `phys_line[t]` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_route | input | 3 | Stored routing bits, one per type |
| cfg_pend | input | 3 | Stored virtual pending bits, one per type |
| cfg_tge | input | 1 | Trap-general-exceptions bit |
| sec_ns | input | 1 | 1 when in non-secure state |
| el3_route | input | 3 | Per-type EL3 routing override |
| cur_el | input | 2 | Current exception level 0 to 3 |
| phys_line | input | 3 | Physical interrupt lines |
| tgt_el | output | 6 | Target level per type, 2 bits each |
| evt_out | output | 3 | Registered physical lines |
| vreq | output | 3 | Virtual interrupt requests |

## Verification
The assertions assume that `cur_el` is 2 only when `sec_ns` is 1, because EL2 has no secure instance in this model. The stimulus never drives EL2 together with secure state. The random sweep forces `sec_ns` high whenever it picks level 2.

The remaining inputs are free. Each property compares outputs against input values sampled one edge earlier, and only after a cycle in which reset was released.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NTYPE = 3;
    localparam int LW    = 2;

    localparam logic [LW-1:0] LVL_NONE = 2'd0;
    localparam logic [LW-1:0] LVL_1    = 2'd1;
    localparam logic [LW-1:0] LVL_2    = 2'd2;
    localparam logic [LW-1:0] LVL_3    = 2'd3;

    typedef struct packed {
        logic [NTYPE-1:0][LW-1:0] tgt;
        logic [NTYPE-1:0]         evt;
        logic [NTYPE-1:0]         vreq;
    } vic_state_s;

    typedef struct packed {
        logic force_route;
        logic route_ok;
        logic virt_ok;
        logic in_el3;
        logic in_el2;
    } vic_ctx_s;
endpackage

// File: rtl/vic_ctx.sv
module vic_ctx
    import vic_pkg::*;
(
    input  logic          tge,
    input  logic          ns,
    input  logic [LW-1:0] cur_el,
    output vic_ctx_s      ctx
);
    always_comb begin
        ctx.in_el3      = (cur_el == LVL_3);
        ctx.in_el2      = (cur_el == LVL_2);
        ctx.route_ok    = ns;
        ctx.force_route = ns & tge;
        ctx.virt_ok     = ns & ~tge & (cur_el <= LVL_1);
    end
endmodule

// File: rtl/vic_lane.sv
module vic_lane
    import vic_pkg::*;
(
    input  vic_ctx_s      ctx,
    input  logic          route_bit,
    input  logic          pend_bit,
    input  logic          el3_bit,
    output logic [LW-1:0] tgt,
    output logic          vreq
);
    logic eff_route;

    always_comb begin
        eff_route = ctx.route_ok & (route_bit | ctx.force_route);
        if (el3_bit)
            tgt = LVL_3;
        else if (ctx.in_el3)
            tgt = LVL_3;
        else if (eff_route)
            tgt = LVL_2;
        else if (ctx.in_el2)
            tgt = LVL_2;
        else
            tgt = LVL_1;
        vreq = pend_bit & route_bit & ctx.virt_ok;
    end
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NTYPE-1:0]    cfg_route,
    input  logic [NTYPE-1:0]    cfg_pend,
    input  logic                cfg_tge,
    input  logic                sec_ns,
    input  logic [NTYPE-1:0]    el3_route,
    input  logic [LW-1:0]       cur_el,
    input  logic [NTYPE-1:0]    phys_line,
    output logic [NTYPE*LW-1:0] tgt_el,
    output logic [NTYPE-1:0]    evt_out,
    output logic [NTYPE-1:0]    vreq
);
    vic_state_s st_d, st_q;
    vic_ctx_s   ctx;
    logic [LW-1:0] lane_tgt  [NTYPE];
    logic          lane_vreq [NTYPE];

    vic_ctx u_ctx (
        .tge    (cfg_tge),
        .ns     (sec_ns),
        .cur_el (cur_el),
        .ctx    (ctx)
    );

    for (genvar t = 0; t < NTYPE; t++) begin : g_lane
        vic_lane u_lane (
            .ctx       (ctx),
            .route_bit (cfg_route[t]),
            .pend_bit  (cfg_pend[t]),
            .el3_bit   (el3_route[t]),
            .tgt       (lane_tgt[t]),
            .vreq      (lane_vreq[t])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int t = 0; t < NTYPE; t++) begin
            st_d.tgt[t]  = lane_tgt[t];
            st_d.vreq[t] = lane_vreq[t];
        end
        st_d.evt = phys_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign tgt_el  = st_q.tgt;
    assign evt_out = st_q.evt;
    assign vreq    = st_q.vreq;

    // R11
    evt_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> evt_out == $past(phys_line));

    // R9
    tge_mutes_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cfg_tge && sec_ns) |-> vreq == '0);

    // R3
    el3_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && cur_el == LVL_3) |-> tgt_el == {NTYPE{LVL_3}});

    for (genvar t = 0; t < NTYPE; t++) begin : g_chk
        // R2
        override_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && el3_route[t]) |-> tgt_el[LW*t +: LW] == LVL_3);

        // R6
        tge_forces_el2_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && cfg_tge && sec_ns && !el3_route[t] && cur_el != LVL_3)
            |-> tgt_el[LW*t +: LW] == LVL_2);

        // R8
        vreq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            vreq[t] |-> $past(cfg_pend[t] && cfg_route[t] && cur_el <= LVL_1));

        // R1
        tgt_never_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> tgt_el[LW*t +: LW] != LVL_NONE);
    end
endmodule

// File: tb/vic_top_test.sv
module vic_top_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_route = '0, cfg_pend = '0, el3_route = '0, phys_line = '0;
    logic       cfg_tge = 1'b0, sec_ns = 1'b0;
    logic [1:0] cur_el = '0;
    logic [5:0] tgt_el;
    logic [2:0] evt_out, vreq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [5:0] tgt;
        logic [2:0] vr;
        logic [2:0] ev;
        string      tag;
    } exp_t;
    exp_t sb[$];

    vic_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_route(cfg_route), .cfg_pend(cfg_pend),
        .cfg_tge(cfg_tge), .sec_ns(sec_ns), .el3_route(el3_route), .cur_el(cur_el),
        .phys_line(phys_line), .tgt_el(tgt_el), .evt_out(evt_out), .vreq(vreq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] exp_tgt(logic rt, logic e3, logic tg, logic n, logic [1:0] el);
        if (e3) return 2'd3;
        if (el == 2'd3) return 2'd3;
        if (n && (rt || tg)) return 2'd2;
        if (el == 2'd2) return 2'd2;
        return 2'd1;
    endfunction

    task automatic apply(input logic [2:0] rt, input logic [2:0] pd, input logic [2:0] e3,
                         input logic tg, input logic n, input logic [1:0] el,
                         input logic [2:0] ph, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_route = rt; cfg_pend = pd; el3_route = e3; cfg_tge = tg;
        sec_ns = n; cur_el = el; phys_line = ph;
        for (int t = 0; t < 3; t++) begin
            e.tgt[2*t +: 2] = exp_tgt(rt[t], e3[t], tg, n, el);
            e.vr[t] = pd[t] & rt[t] & n & ~tg & (el <= 2'd1);
        end
        e.ev = ph;
        e.tag = tag;
        sb.push_back(e);
    endtask

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (tgt_el !== e.tgt || vreq !== e.vr || evt_out !== e.ev) begin
                errors++;
                $display("FAIL %s tgt=%h vreq=%b evt=%b expected tgt=%h vreq=%b evt=%b",
                         e.tag, tgt_el, vreq, evt_out, e.tgt, e.vr, e.ev);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        // R1: reset state with busy inputs
        cfg_route = 3'b111; cfg_pend = 3'b111; sec_ns = 1'b1; phys_line = 3'b111;
        repeat (3) @(negedge clk);
        checks++;
        if (tgt_el !== 6'd0 || vreq !== 3'd0 || evt_out !== 3'd0) begin
            errors++;
            $display("FAIL R1 tgt=%h vreq=%b evt=%b expected 00 000 000", tgt_el, vreq, evt_out);
        end
        rst_n = 1'b1;

        // R2 override beats everything
        apply(3'b111, 3'b111, 3'b101, 1'b1, 1'b1, 2'd1, 3'b000, "R2");
        apply(3'b000, 3'b000, 3'b010, 1'b0, 1'b0, 2'd0, 3'b000, "R2");
        // R3 current EL3
        apply(3'b000, 3'b111, 3'b000, 1'b0, 1'b1, 2'd3, 3'b010, "R3");
        // R4 routing bit to EL2
        apply(3'b011, 3'b000, 3'b000, 1'b0, 1'b1, 2'd1, 3'b000, "R4");
        apply(3'b100, 3'b000, 3'b000, 1'b0, 1'b1, 2'd2, 3'b000, "R4");
        // R5 clear routing
        apply(3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 2'd0, 3'b000, "R5");
        apply(3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 2'd2, 3'b000, "R5");
        // R6 trap forces EL2
        apply(3'b000, 3'b000, 3'b000, 1'b1, 1'b1, 2'd0, 3'b000, "R6");
        apply(3'b000, 3'b000, 3'b001, 1'b1, 1'b1, 2'd1, 3'b000, "R6");
        // R7 secure ignores routing and trap
        apply(3'b111, 3'b111, 3'b000, 1'b1, 1'b0, 2'd1, 3'b000, "R7");
        // R8 virtual requests
        apply(3'b111, 3'b101, 3'b000, 1'b0, 1'b1, 2'd1, 3'b000, "R8");
        apply(3'b010, 3'b111, 3'b000, 1'b0, 1'b1, 2'd0, 3'b000, "R8");
        apply(3'b111, 3'b111, 3'b000, 1'b0, 1'b1, 2'd2, 3'b000, "R8");
        // R9 trap suppresses virtual requests
        apply(3'b111, 3'b111, 3'b000, 1'b1, 1'b1, 2'd1, 3'b000, "R9");
        // R11 line mirror
        apply(3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 2'd1, 3'b101, "R11");
        apply(3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 2'd1, 3'b010, "R11");

        // R10: new inputs do not reach outputs before the edge
        apply(3'b111, 3'b111, 3'b000, 1'b0, 1'b1, 2'd1, 3'b000, "R10");
        @(negedge clk);
        cfg_route = 3'b000; cfg_tge = 1'b1;
        #1;
        checks++;
        if (vreq !== 3'b111 || tgt_el !== 6'b101010) begin
            errors++;
            $display("FAIL R10 vreq=%b tgt=%h expected 111 2a", vreq, tgt_el);
        end
        apply(3'b000, 3'b111, 3'b000, 1'b1, 1'b1, 2'd1, 3'b000, "R10");

        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 300; i++) begin
            logic n;
            logic [1:0] el;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            el = lfsr[13:12];
            n  = (el == 2'd2) ? 1'b1 : lfsr[14];
            apply(lfsr[2:0], lfsr[5:3], lfsr[8:6] & lfsr[11:9], lfsr[15] & lfsr[16],
                  n, el, lfsr[19:17], "R4 R5 R8 sweep");
        end

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule